// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock static RAM model with a two-stage read pipeline, byte-lane writes and a built-in four-beat burst address generator. Address, write data, strobes and chip enables are sampled on the rising clock edge. A read command fetches the word from the array at that edge into an internal register. The word then moves through an output register and appears on the data port one edge later. Output enable and sleep act on the drive-enable output without a clock.

There are two command strobes. The processor strobe always opens a read, and enable 1 high shuts it out. The controller strobe can open a read or a write, and it deselects the chip when the enables do not match. When both strobes are high, an open access either moves to the next burst address or stays on the current one. The write inputs sampled at that edge decide whether the beat reads or writes. The data port is a plain output with a separate drive-enable flag instead of a tri-state pin.

Top module: `burst_sram`

## Requirements
- R1: A read command sampled at edge N sets dout to the addressed word and dout_en high after edge N+1, provided oe_n is low and sleep is low.
- R2: A strobe opens an access only when ce1_n=0, ce2=1 and ce3_n=0 at that edge. Any other combination on a strobe that is not shut out deselects the chip.
- R3: strb_proc_n low with ce1_n low always opens a read and never writes, whatever the write inputs are. strb_proc_n low with ce1_n high is ignored, so an open burst goes on as if both strobes were high.
- R4: strb_ctrl_n low, with the processor strobe not taking effect, opens a read or a write at the external address. If the enables fail, it deselects the chip.
- R5: Write decode. gwe_n=0 writes all lanes. Otherwise we_n=0 writes each lane i whose be_n[i]=0, where lane i is din[8i+7:8i]. we_n=0 with every be_n bit high is a read.
- R6: With both strobes high and an access open, adv_n=0 moves to the next burst address and adv_n=1 repeats the current one. The write inputs of that edge choose between read and write.
- R7: The low two address bits of beat k (k=0..3) from start s are (s+k) mod 4 when order_il=0 and s XOR k when order_il=1. The upper address bits stay fixed for the whole burst.
- R8: dout_en is low at once whenever oe_n is high or sleep is high.
- R9: A deselect or write command at edge N makes dout_en low after edge N+1.
- R10: While sleep is high, no read or write happens, the chip is deselected and the array keeps its contents. After sleep falls, the chip stays idle until a strobe opens a new access.
- R11: strb_ctrl_n low with adv_n high on every clock accepts a new external address each cycle, with no burst advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address |
| din | input | NB*BW | Write data |
| ce1_n | input | 1 | Enable 1, active low, also gates the processor strobe |
| ce2 | input | 1 | Enable 2, active high |
| ce3_n | input | 1 | Enable 3, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write, active low |
| we_n | input | 1 | Lane write enable, active low |
| be_n | input | NB | Per-lane byte enables, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep, active high, combinational on the output |
| dout | output | NB*BW | Registered read data |
| dout_en | output | 1 | Data drive enable (low means high impedance) |

## Verification
Every address is written and read back with single-cycle controller commands. This shows that a new address is taken each clock and that the two-edge read latency holds. All four start offsets are burst-read in both orders, which separates linear wrap from XOR ordering. A sweep over the byte-enable patterns, plus a global write with the lane inputs inactive, separates lane masking from global override. Directed sequences cover deselect by each enable, the shut-out processor strobe, write inputs on a processor start, and sleep entry and exit with the data kept across it.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BURST_BITS = 2;
  typedef logic [BURST_BITS-1:0] beat_t;

  // Low address bits for beat k of a burst starting at s.
  function automatic beat_t beat_addr(input beat_t s, input beat_t k, input logic il);
    return il ? (s ^ k) : beat_t'(s + k);
  endfunction

  // Lane write request from the raw write inputs.
  function automatic logic lane_req(input logic gwe_n, input logic we_n, input logic be_n_i);
    return !gwe_n || (!we_n && !be_n_i);
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          order_il,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] acc_addr
);
  localparam int HW = AW - BURST_BITS;

  logic [HW-1:0] base_hi;
  beat_t         base_lo;
  beat_t         cnt;
  beat_t         cnt_use;

  assign cnt_use  = step ? beat_t'(cnt + 1'b1) : cnt;
  assign acc_addr = load ? load_addr : {base_hi, beat_addr(base_lo, cnt_use, order_il)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      cnt     <= '0;
    end else if (load) begin
      base_hi <= load_addr[AW-1:BURST_BITS];
      base_lo <= load_addr[BURST_BITS-1:0];
      cnt     <= '0;
    end else if (step) begin
      cnt <= cnt_use;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic [NB-1:0]    lane_we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [BW-1:0] mem [DEPTH][NB];

  always_ff @(posedge clk) begin
    for (int l = 0; l < NB; l++) begin
      if (lane_we[l]) mem[addr][l] <= wdata[l*BW +: BW];
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      for (int l = 0; l < NB; l++) rdata[l*BW +: BW] <= mem[addr][l];
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] din,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             strb_proc_n,
  input  logic             strb_ctrl_n,
  input  logic             adv_n,
  input  logic             gwe_n,
  input  logic             we_n,
  input  logic [NB-1:0]    be_n,
  input  logic             oe_n,
  input  logic             order_il,
  input  logic             sleep,
  output logic [NB*BW-1:0] dout,
  output logic             dout_en
);
  localparam int DW = NB * BW;

  logic          active_q, rd1_q, vld_q;
  logic [DW-1:0] arr_q, dout_q;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] lane_rq, lane_we;

  // Command decode, brought out as named wires for the checker.
  logic chip_ok, p_go, c_go, cont, write_ok;
  logic cmd_start, cmd_desel, cmd_write, cmd_read, cmd_step;

  assign chip_ok  = !ce1_n && ce2 && !ce3_n;
  assign p_go     = !sleep && !strb_proc_n && !ce1_n;
  assign c_go     = !sleep && !p_go && !strb_ctrl_n;
  assign cont     = !sleep && !p_go && strb_ctrl_n && active_q;
  assign write_ok = (c_go && chip_ok) || cont;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane_rq[g] = lane_req(gwe_n, we_n, be_n[g]);
    end
  endgenerate

  assign lane_we   = write_ok ? lane_rq : '0;
  assign cmd_write = |lane_we;
  assign cmd_start = (p_go || c_go) && chip_ok;
  assign cmd_desel = sleep || ((p_go || c_go) && !chip_ok);
  assign cmd_read  = (p_go && chip_ok) || (write_ok && !cmd_write);
  assign cmd_step  = cont && !adv_n;

  burst_addr_gen #(.AW(AW)) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_start),
    .step      (cmd_step),
    .order_il  (order_il),
    .load_addr (addr),
    .acc_addr  (acc_addr)
  );

  sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .re      (cmd_read),
    .addr    (acc_addr),
    .wdata   (din),
    .rdata   (arr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd1_q    <= 1'b0;
      vld_q    <= 1'b0;
      dout_q   <= '0;
    end else begin
      if (cmd_desel)      active_q <= 1'b0;
      else if (cmd_start) active_q <= 1'b1;
      rd1_q <= cmd_read;
      vld_q <= rd1_q;
      if (rd1_q) dout_q <= arr_q;
    end
  end

  assign dout    = dout_q;
  assign dout_en = vld_q && !oe_n && !sleep;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic oe_n,
  input logic ce1_n,
  input logic strb_proc_n,
  input logic strb_ctrl_n,
  input logic dout_en,
  input logic cmd_read,
  input logic cmd_write,
  input logic cmd_desel
);
  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_read |-> ##2 (dout_en || oe_n || sleep));

  // R9
  desel_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_desel || cmd_write) |-> ##2 !dout_en);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || sleep) |-> !dout_en);

  // R3
  proc_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !ce1_n) |-> !cmd_write);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!cmd_read && !cmd_write));

  // R10
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep) && strb_proc_n && strb_ctrl_n) |-> (!cmd_read && !cmd_write));
endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep       (sleep),
  .oe_n        (oe_n),
  .ce1_n       (ce1_n),
  .strb_proc_n (strb_proc_n),
  .strb_ctrl_n (strb_ctrl_n),
  .dout_en     (dout_en),
  .cmd_read    (cmd_read),
  .cmd_write   (cmd_write),
  .cmd_desel   (cmd_desel)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
  logic gwe_n = 1'b1, we_n = 1'b1;
  logic [NB-1:0] be_n = '1;
  logic oe_n = 1'b0, order_il = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dout;
  logic dout_en;

  logic [DW-1:0] model [DEPTH];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_sram #(.AW(AW), .NB(NB), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .gwe_n(gwe_n), .we_n(we_n), .be_n(be_n), .oe_n(oe_n),
    .order_il(order_il), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
    gwe_n = 1'b1; we_n = 1'b1; be_n = '1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  task automatic model_wr(input int a, input logic [DW-1:0] d, input logic gw,
                          input logic we, input logic [NB-1:0] be);
    for (int l = 0; l < NB; l++)
      if (!gw || (!we && !be[l])) model[a][l*BW +: BW] = d[l*BW +: BW];
  endtask

  task automatic rd_chk(input int a, input string tag);
    idle_in(); strb_ctrl_n = 1'b0; addr = AW'(a);
    tick();
    idle_in();
    tick();
    chk({tag, " en"}, 32'(dout_en), 32'd1);
    chk({tag, " data"}, 32'(dout), 32'(model[a]));
  endtask

  function automatic int beat(input int a, input int k, input bit il);
    int s = a & 3;
    return (a & ~3) | (il ? (s ^ k) : ((s + k) & 3));
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset dout_en", 32'(dout_en), 32'd0);

    // R11 R5: fill every word, one new address per clock, global write
    for (int a = 0; a < DEPTH; a++) begin
      idle_in(); strb_ctrl_n = 1'b0; gwe_n = 1'b0; addr = AW'(a);
      din = DW'(a * 16'h0123 + 16'h5a3c);
      model_wr(a, din, 1'b0, 1'b1, '1);
      tick();
    end
    // R11 R1: back-to-back single reads, data two edges after command
    for (int a = 0; a <= DEPTH; a++) begin
      idle_in();
      if (a < DEPTH) begin strb_ctrl_n = 1'b0; addr = AW'(a); end
      tick();
      if (a > 0) begin
        chk("R11 pipelined read", 32'(dout), 32'(model[a-1]));
        chk("R1 read en", 32'(dout_en), 32'd1);
      end
    end

    // R7 R6: burst reads from every offset, both orders
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        order_il = il[0];
        for (int k = 0; k <= 4; k++) begin
          idle_in();
          if (k == 0) begin strb_proc_n = 1'b0; addr = AW'(4 + s); end
          else if (k < 4) adv_n = 1'b0;
          tick();
          if (k >= 1) chk(il ? "R7 interleaved beat" : "R7 linear beat",
                          32'(dout), 32'(model[beat(4 + s, k - 1, il[0])]));
        end
      end
    end
    order_il = 1'b0;

    // R5 R9: byte-lane sweep at word 6
    for (int p = 0; p < 4; p++) begin
      idle_in(); strb_ctrl_n = 1'b0; we_n = 1'b0; be_n = NB'(p); addr = AW'(6);
      din = DW'(16'hc1d0 + p * 16'h1111);
      model_wr(6, din, 1'b1, 1'b0, NB'(p));
      tick();
      idle_in();
      tick();
      if (p != 3) chk("R9 write hides bus", 32'(dout_en), 32'd0);
      tick();
      chk("R5 lane write", 32'(dout), 32'(model[6]));
    end
    // R5: global write overrides inactive lane inputs
    idle_in(); strb_ctrl_n = 1'b0; gwe_n = 1'b0; we_n = 1'b1; be_n = '1;
    addr = AW'(7); din = 16'hbeef; model_wr(7, din, 1'b0, 1'b1, '1);
    tick();
    rd_chk(7, "R5 global write");

    // R3: processor strobe ignores write inputs
    idle_in(); strb_proc_n = 1'b0; gwe_n = 1'b0; we_n = 1'b0; be_n = '0;
    addr = AW'(5); din = 16'hdead;
    tick();
    idle_in(); tick();
    rd_chk(5, "R3 proc start no write");

    // R6 R4: write burst via controller strobe, linear from 9
    for (int k = 0; k < 4; k++) begin
      idle_in(); gwe_n = 1'b0; din = DW'(16'h7000 + k);
      if (k == 0) begin strb_ctrl_n = 1'b0; addr = AW'(9); end
      else adv_n = 1'b0;
      model_wr(beat(9, k, 1'b0), din, 1'b0, 1'b1, '1);
      tick();
    end
    for (int k = 0; k < 4; k++) rd_chk(beat(9, k, 1'b0), "R6 burst write");

    // R3: processor strobe with ce1_n high keeps the burst going
    idle_in(); strb_proc_n = 1'b0; addr = AW'(0); tick();
    idle_in(); strb_proc_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0; addr = AW'(13); tick();
    chk("R3 blocked strobe beat0", 32'(dout), 32'(model[0]));
    idle_in(); tick();
    chk("R3 blocked strobe en", 32'(dout_en), 32'd1);
    chk("R3 blocked strobe beat1", 32'(dout), 32'(model[1]));

    // R2 R9: processor start with ce3_n high deselects
    idle_in(); strb_proc_n = 1'b0; ce3_n = 1'b1; tick();
    chk("R9 desel en one edge", 32'(dout_en), 32'd1);
    idle_in(); tick();
    chk("R2 ce3 deselect", 32'(dout_en), 32'd0);
    // R4: controller start with ce2 low deselects
    rd_chk(2, "R4 reopen");
    idle_in(); strb_ctrl_n = 1'b0; ce2 = 1'b0; tick();
    idle_in(); tick();
    chk("R4 ce2 deselect", 32'(dout_en), 32'd0);

    // R8: output enable acts without a clock
    rd_chk(3, "R8 setup");
    #1 oe_n = 1'b1; #0.5;
    chk("R8 oe high", 32'(dout_en), 32'd0);
    oe_n = 1'b0; #0.5;
    chk("R8 oe low", 32'(dout_en), 32'd1);

    // R10: sleep blocks writes, keeps data, idles after release
    tick();
    sleep = 1'b1; #0.5;
    chk("R10 sleep hides bus", 32'(dout_en), 32'd0);
    idle_in(); strb_ctrl_n = 1'b0; gwe_n = 1'b0; addr = AW'(3); din = 16'h0bad;
    tick();
    idle_in(); tick();
    sleep = 1'b0;
    tick(); tick();
    chk("R10 idle after wake", 32'(dout_en), 32'd0);
    rd_chk(3, "R10 data kept");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule